// File: doc/BRIEF.md
# Oscillator Enable Sweep Controller

This block produces one enable line for a large bank of free-running oscillators that is treated purely as an electrical load. The line stays low until a single command byte arrives on a received-byte strobe from a serial receiver. The command byte is a lowercase 's' (0x73). The block then gates the bank on and off with a pulse train. The train's period grows stage by stage, so the toggle frequency falls. Inside every stage the share of each period spent switched on rises in eighths.

Two blink counters run beside the sweep as health monitors. Each drives its own LED and toggles it once per second. The counters share no state with each other or with the sweep. Under stress, a disturbance can therefore show up as the two LEDs drifting apart.

Top module: `osc_sweep_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `osc_en`, `led_a` and `led_b` are all low and no sweep is running.
- R2: A sweep starts when `rx_valid` is high with `rx_byte` equal to 0x73 while idle, and `osc_en` is high in the following cycle.
- R3: When idle, a strobe carrying any byte other than 0x73 has no effect, and `osc_en` stays low.
- R4: During a step with duty index d (1 to 7), each period of P cycles begins with `osc_en` high for d*P/8 cycles and ends with it low for the rest.
- R5: There are NUM_STAGES stages, and stage k (counting from 0) uses the period P = BASE_PERIOD << k, so each stage toggles at half the frequency of the one before it.
- R6: Within a stage, the duty index runs 1, 2, ... 7 in ascending order, and each index lasts PERIODS_PER_STEP whole periods.
- R7: A 0x73 strobe that arrives while a sweep is running is ignored, and the sequence continues without restarting.
- R8: After the last period of duty 7 in the last stage, `osc_en` returns low and the block is idle, and a new 0x73 starts a fresh sweep.
- R9: `led_a` toggles every BLINK_CYCLES clock cycles after reset.
- R10: `led_b` toggles every BLINK_CYCLES clock cycles from its own counter, stays in step with `led_a`, and is unaffected by the sweep and by received bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| osc_en | output | 1 | Enable for the oscillator bank |
| led_a | output | 1 | First health blink LED |
| led_b | output | 1 | Second health blink LED |

## Verification
The bench builds the block with BASE_PERIOD = 8, NUM_STAGES = 8, PERIODS_PER_STEP = 2 and BLINK_CYCLES = 50. With these values the whole sweep, from the one-cycle-high step at the shortest period through the 1024-cycle period at 7/8 duty, completes in under 30,000 cycles. Each period of every step, the end of the sweep and a second sweep all fall within one run. The short blink interval gives hundreds of LED toggles over the same run, so both blink counters are seen while the oscillator bank is gated on and off.

// File: rtl/osc_sweep_pkg.sv
package osc_sweep_pkg;
   // Number of duty subdivisions per period (eighths) and its log2.
   localparam int unsigned DUTY_DIVS  = 8;
   localparam int unsigned DUTY_SHIFT = 3;
   localparam int unsigned DUTY_MAX   = DUTY_DIVS - 1;
   localparam logic [7:0]  CMD_SWEEP  = 8'h73;

   typedef logic [2:0] duty_idx_t;
endpackage

// File: rtl/osc_cmd_match.sv
module osc_cmd_match
   import osc_sweep_pkg::*;
#(
   parameter logic [7:0] CMD = CMD_SWEEP
) (
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       busy,
   output logic       start
);
   // Only an idle sequencer accepts the command; anything else is dropped.
   always_comb begin
      start = rx_valid && (rx_byte == CMD) && !busy;
   end
endmodule

// File: rtl/osc_sweep_seq.sv
module osc_sweep_seq
   import osc_sweep_pkg::*;
#(
   parameter int unsigned BASE_PERIOD      = 1024,
   parameter int unsigned NUM_STAGES       = 8,
   parameter int unsigned PERIODS_PER_STEP = 16,
   localparam int unsigned SW  = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
   localparam int unsigned PW  = $clog2(BASE_PERIOD) + NUM_STAGES,
   localparam int unsigned CW  = (PERIODS_PER_STEP > 1) ? $clog2(PERIODS_PER_STEP) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [SW-1:0] stage,
   output duty_idx_t     duty,
   output logic [PW-1:0] phase,
   output logic [PW-1:0] period_len
);
   localparam logic [SW-1:0] STAGE_LAST = SW'(NUM_STAGES - 1);
   localparam logic [CW-1:0] CNT_LAST   = CW'(PERIODS_PER_STEP - 1);
   localparam duty_idx_t     DUTY_LAST  = duty_idx_t'(DUTY_MAX);

   logic [CW-1:0] per_cnt;
   logic          end_period, end_step, end_stage, end_sweep;

   always_comb begin
      period_len = PW'(BASE_PERIOD) << stage;
      end_period = (phase == period_len - PW'(1));
      end_step   = end_period && (per_cnt == CNT_LAST);
      end_stage  = end_step && (duty == DUTY_LAST);
      end_sweep  = end_stage && (stage == STAGE_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         stage   <= '0;
         duty    <= duty_idx_t'(1);
         per_cnt <= '0;
         phase   <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         stage   <= '0;
         duty    <= duty_idx_t'(1);
         per_cnt <= '0;
         phase   <= '0;
      end else if (busy) begin
         phase <= end_period ? '0 : phase + PW'(1);
         if (end_period)
            per_cnt <= end_step ? '0 : per_cnt + CW'(1);
         if (end_step)
            duty <= end_stage ? duty_idx_t'(1) : duty + duty_idx_t'(1);
         if (end_stage && !end_sweep)
            stage <= stage + SW'(1);
         if (end_sweep) begin
            busy  <= 1'b0;
            stage <= '0;
         end
      end
   end
endmodule

// File: rtl/osc_pulse_gate.sv
module osc_pulse_gate
   import osc_sweep_pkg::*;
#(
   parameter int unsigned PW = 18
) (
   input  logic          busy,
   input  duty_idx_t     duty,
   input  logic [PW-1:0] phase,
   input  logic [PW-1:0] period_len,
   output logic          gate
);
   logic [PW+2:0] on_scaled;
   logic [PW-1:0] on_len;

   always_comb begin
      on_scaled = (PW+3)'(duty) * (PW+3)'(period_len);
      on_len    = PW'(on_scaled >> DUTY_SHIFT);
      gate      = busy && (phase < on_len);
   end
endmodule

// File: rtl/osc_blink.sv
module osc_blink #(
   parameter int unsigned BLINK_CYCLES = 100_000_000,
   localparam int unsigned BW = (BLINK_CYCLES > 1) ? $clog2(BLINK_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic led
);
   localparam logic [BW-1:0] WRAP = BW'(BLINK_CYCLES - 1);
   logic [BW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         led <= 1'b0;
      end else if (cnt == WRAP) begin
         cnt <= '0;
         led <= !led;
      end else begin
         cnt <= cnt + BW'(1);
      end
   end
endmodule

// File: rtl/osc_sweep_ctrl.sv
module osc_sweep_ctrl
   import osc_sweep_pkg::*;
#(
   parameter int unsigned BASE_PERIOD      = 1024,
   parameter int unsigned NUM_STAGES       = 8,
   parameter int unsigned PERIODS_PER_STEP = 16,
   parameter int unsigned BLINK_CYCLES     = 100_000_000,
   parameter int unsigned NUM_BLINKERS     = 2,
   localparam int unsigned SW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
   localparam int unsigned PW = $clog2(BASE_PERIOD) + NUM_STAGES
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   output logic       osc_en,
   output logic       led_a,
   output logic       led_b
);
   // Elaboration-time parameter checks.
   if (BASE_PERIOD < DUTY_DIVS || (BASE_PERIOD % DUTY_DIVS) != 0) begin : g_bad_base
      $error("BASE_PERIOD must be a nonzero multiple of the duty subdivision");
   end
   if (NUM_STAGES < 1) begin : g_bad_stages
      $error("NUM_STAGES must be at least one");
   end
   if (PERIODS_PER_STEP < 1) begin : g_bad_pps
      $error("PERIODS_PER_STEP must be at least one");
   end
   if (BLINK_CYCLES < 2) begin : g_bad_blink
      $error("BLINK_CYCLES must be at least two");
   end
   if (NUM_BLINKERS != 2) begin : g_bad_blinkers
      $error("exactly two blink monitors are brought out");
   end

   logic          start, busy;
   logic [SW-1:0] stage;
   duty_idx_t     duty;
   logic [PW-1:0] phase, period_len;
   logic [NUM_BLINKERS-1:0] leds;

   osc_cmd_match #(.CMD(CMD_SWEEP)) u_cmd (
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .busy     (busy),
      .start    (start)
   );

   osc_sweep_seq #(
      .BASE_PERIOD      (BASE_PERIOD),
      .NUM_STAGES       (NUM_STAGES),
      .PERIODS_PER_STEP (PERIODS_PER_STEP)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .busy       (busy),
      .stage      (stage),
      .duty       (duty),
      .phase      (phase),
      .period_len (period_len)
   );

   osc_pulse_gate #(.PW(PW)) u_gate (
      .busy       (busy),
      .duty       (duty),
      .phase      (phase),
      .period_len (period_len),
      .gate       (osc_en)
   );

   // Each monitor owns its counter and LED register; nothing is shared.
   for (genvar i = 0; i < NUM_BLINKERS; i++) begin : g_blink
      osc_blink #(.BLINK_CYCLES(BLINK_CYCLES)) u_blink (
         .clk   (clk),
         .rst_n (rst_n),
         .led   (leds[i])
      );
   end

   assign led_a = leds[0];
   assign led_b = leds[NUM_BLINKERS-1];
endmodule

// File: rtl/osc_sweep_chk.sv
module osc_sweep_chk #(
   parameter int unsigned NUM_STAGES = 8,
   parameter int unsigned SW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic [7:0]    rx_byte,
   input logic          osc_en,
   input logic          led_a,
   input logic          led_b,
   input logic          busy,
   input logic [SW-1:0] stage,
   input logic [2:0]    duty
);
   // R2: command accepted while idle starts the sweep with enable high.
   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rx_valid && rx_byte == 8'h73) |=> (busy && osc_en));

   // R3: any other byte while idle leaves the enable low.
   a_r3_other_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rx_valid && rx_byte != 8'h73) |=> (!busy && !osc_en));

   // R5: stage index never passes the last stage and never goes backwards.
   a_r5_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (32'(stage) < NUM_STAGES));
   a_r5_stage_mono: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (stage >= $past(stage)));

   // R6: duty index stays within one to seven eighths.
   a_r6_duty_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (duty >= 3'd1 && duty <= 3'd7));

   // R7: a command during a sweep does not restart it.
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && stage != '0 && rx_valid) |=> (!busy || stage != '0));

   // R8: once the sweep ends the enable is low.
   a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !osc_en);

   // R10: both monitors stay in step.
   a_r10_leds_same: assert property (@(posedge clk) disable iff (!rst_n)
      led_a == led_b);
endmodule

bind osc_sweep_ctrl osc_sweep_chk #(.NUM_STAGES(NUM_STAGES), .SW(SW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_valid (rx_valid),
   .rx_byte  (rx_byte),
   .osc_en   (osc_en),
   .led_a    (led_a),
   .led_b    (led_b),
   .busy     (busy),
   .stage    (stage),
   .duty     (duty)
);

// File: tb/sim_osc_sweep_ctrl.sv
`timescale 1ns/1ps
module sim_osc_sweep_ctrl;
   localparam int BASE  = 8;
   localparam int STG   = 8;
   localparam int PPS   = 2;
   localparam int BLINK = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic osc_en, led_a, led_b;

   always #2.5 clk = ~clk;

   osc_sweep_ctrl #(
      .BASE_PERIOD(BASE), .NUM_STAGES(STG),
      .PERIODS_PER_STEP(PPS), .BLINK_CYCLES(BLINK)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .osc_en(osc_en), .led_a(led_a), .led_b(led_b)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: sweep position and blink counters as integers.
   bit m_busy = 0;
   int m_stage = 0, m_duty = 1, m_pcnt = 0, m_phase = 0;
   int m_bcnt_a = 0, m_bcnt_b = 0;
   bit m_led_a = 0, m_led_b = 0;
   bit m_en = 0;
   int sweeps_done = 0;

   function automatic int period_of(input int k);
      return BASE << k;  // R5: period doubles per stage
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_stage = 0; m_duty = 1; m_pcnt = 0; m_phase = 0;
         m_bcnt_a = 0; m_bcnt_b = 0; m_led_a = 0; m_led_b = 0;
      end else begin
         if (!m_busy) begin
            if (rx_valid && rx_byte == 8'h73) begin  // R2 / R3
               m_busy = 1; m_stage = 0; m_duty = 1; m_pcnt = 0; m_phase = 0;
            end
         end else begin  // R7: bytes ignored while running
            m_phase++;
            if (m_phase == period_of(m_stage)) begin
               m_phase = 0;
               m_pcnt++;
               if (m_pcnt == PPS) begin  // R6
                  m_pcnt = 0;
                  m_duty++;
                  if (m_duty == 8) begin
                     m_duty = 1;
                     m_stage++;
                     if (m_stage == STG) begin  // R8
                        m_busy = 0; m_stage = 0;
                        sweeps_done++;
                     end
                  end
               end
            end
         end
         if (m_bcnt_a == BLINK - 1) begin m_bcnt_a = 0; m_led_a = !m_led_a; end
         else m_bcnt_a++;
         if (m_bcnt_b == BLINK - 1) begin m_bcnt_b = 0; m_led_b = !m_led_b; end
         else m_bcnt_b++;
      end
      // R4: high for the first duty/8 of each period
      m_en = m_busy && (m_phase < (m_duty * period_of(m_stage)) / 8);
   end

   // Compare every clock, away from the active edge.
   bit cmp_on = 0;
   always @(negedge clk) begin
      if (cmp_on) begin
         chk(osc_en === m_en, "R4", int'(osc_en), int'(m_en));
         chk(led_a === m_led_a, "R9", int'(led_a), int'(m_led_a));
         chk(led_b === m_led_b, "R10", int'(led_b), int'(m_led_b));
      end
   end

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0; rx_byte = 8'h00;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   bit finished = 0;

   initial begin
      idle(4);
      // R1: outputs low in reset
      chk(osc_en === 1'b0, "R1", int'(osc_en), 0);
      chk(led_a === 1'b0 && led_b === 1'b0, "R1", int'({led_a, led_b}), 0);
      rst_n = 1'b1;
      cmp_on = 1;
      @(negedge clk);
      chk(osc_en === 1'b0, "R1", int'(osc_en), 0);
      idle(10);
      // R3: other bytes ignored
      send(8'h53);
      chk(osc_en === 1'b0, "R3", int'(osc_en), 0);
      send(8'h00);
      send(8'hF3);
      idle(3);
      chk(osc_en === 1'b0, "R3", int'(osc_en), 0);
      // R2: the command starts the sweep; enable high the next cycle
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = 8'h73;
      @(negedge clk);
      rx_valid = 1'b0;
      chk(osc_en === 1'b1, "R2", int'(osc_en), 1);
      // First period: duty 1/8 of 8 cycles -> exactly one high cycle (R4, R6)
      @(negedge clk);
      chk(osc_en === 1'b0, "R6", int'(osc_en), 0);
      idle(200);
      // R7: second command mid-sweep must not restart
      send(8'h73);
      idle(1000);
      send(8'h73);
      // R5 / R6 / R4 covered by the per-clock comparison while waiting
      while (sweeps_done == 0) @(negedge clk);
      // R8: enable low and idle after the final step
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk(osc_en === 1'b0, "R8", int'(osc_en), 0);
      end
      // R8: a fresh command restarts
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = 8'h73;
      @(negedge clk);
      rx_valid = 1'b0;
      chk(osc_en === 1'b1, "R8", int'(osc_en), 1);
      idle(300);
      finished = 1;
   end

   initial begin
      for (int i = 0; i < 150000; i++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule